// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one core's load/store unit and decides whether a store-conditional may write. A load-linked records a reservation on the 64-byte line that holds its address. A later store-conditional succeeds only if that reservation is still valid and the store falls in the same line. The decision rests on line addresses, never on data values. A write by another agent to the line therefore breaks the sequence even if the old value was written back afterwards.

The reservation is dropped on four events. Another agent's write or a loss of line ownership arrives as a snoop-invalidate. The core's own ordinary loads and stores also drop it, as does the core taking an interrupt. The core then sees the failure when it retries the atomic sequence after the handler returns. Each store-conditional gets a one-cycle result pulse, and the store is committed only when that pulse reports success.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset, no reservation is held, and both `sc_done` and `sc_success` are 0.
- R2: A load-linked followed by a store-conditional to the same 64-byte line succeeds, whatever address bits [5:0] each carries. The result appears the cycle after the store-conditional is presented: `sc_done` is 1 for exactly that one cycle, and `sc_success` is 1 in it.
- R3: A store-conditional to a different line than the reserved one fails.
- R4: A snoop-invalidate to the reserved line fails the next store-conditional. This holds when the snoop arrives between the load-linked and the store-conditional, and when it arrives in the same cycle as the store-conditional. A snoop to another line has no effect.
- R5: Any ordinary load or store by the core between the load-linked and the store-conditional cancels the reservation, whatever its address.
- R6: `irq_taken` cancels the reservation. If it is asserted in the same cycle as a store-conditional, that store-conditional fails.
- R7: Every store-conditional clears the reservation, whether it succeeds or fails, so a second store-conditional fails.
- R8: A new load-linked replaces the existing reservation.
- R9: A store-conditional with no valid reservation reports failure (`sc_success` = 0), which means the store is not performed.
- R10: `req_op` is encoded as 0 none, 1 load, 2 store, 3 load-linked, 4 store-conditional. A request acts only while `req_valid` is 1, and idle cycles leave the reservation untouched.
- R11: A load-linked does not establish a reservation if, in the same cycle, a snoop-invalidate hits its own line or an interrupt is taken. A snoop to another line in that cycle does not block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 3 | Request kind (see R10) |
| req_addr | input | 32 | Request byte address |
| snoop_valid | input | 1 | Invalidate or ownership loss from another agent |
| snoop_addr | input | 32 | Byte address of the snooped line |
| irq_taken | input | 1 | Core is entering an interrupt handler |
| sc_done | output | 1 | Store-conditional result valid (one cycle) |
| sc_success | output | 1 | Store-conditional may commit |

## Verification
The bench uses addresses with different offset bits inside one line. A monitor that compared full byte addresses would then fail legal pairs, and one that ignored too many bits would pass cross-line pairs. It applies snoops and interrupts both between the two instructions and in the same cycle as the load-linked or the store-conditional. A design that looked only at the stored reservation would let an interrupted or snooped store-conditional through, and one with the wrong set/clear priority would lose a fresh reservation or keep a blocked one. A repeated store-conditional, a replacing load-linked and a stream of idle cycles with stray opcodes expose a monitor that keeps the reservation too long or drops it on non-requests.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    parameter int ADDR_W     = 32;
    parameter int LINE_BYTES = 64;
    localparam int OFS_W     = $clog2(LINE_BYTES);
    localparam int TAG_W     = ADDR_W - OFS_W;
    localparam int N_PROBES  = 3;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_LL    = 3'd3,
        OP_SC    = 3'd4
    } op_e;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } resv_t;

    function automatic tag_t line_of(input addr_t a);
        return tag_t'(a >> OFS_W);
    endfunction
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match
    import llsc_pkg::*;
(
    input  logic  en,
    input  tag_t  ref_tag,
    input  addr_t addr,
    output logic  hit
);
    always_comb hit = en && (line_of(addr) == ref_tag);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg
    import llsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_en,
    input  tag_t  set_tag,
    input  logic  kill,
    output resv_t resv
);
    resv_t resv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
        end else if (set_en) begin
            resv_q.valid <= 1'b1;
            resv_q.tag   <= set_tag;
        end else if (kill) begin
            resv_q.valid <= 1'b0;
        end
    end

    assign resv = resv_q;

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !resv_q.valid);
    a_r8_set_loads_tag: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (resv_q.valid && resv_q.tag == $past(set_tag)));
endmodule

// File: rtl/llsc_sc_eval.sv
module llsc_sc_eval (
    input  logic clk,
    input  logic rst,
    input  logic sc_req,
    input  logic line_hit,
    input  logic interfere,
    output logic done,
    output logic ok
);
    logic done_q, ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= sc_req;
            ok_q   <= sc_req && line_hit && !interfere;
        end
    end

    assign done = done_q;
    assign ok   = ok_q;

    a_r2_success_only_with_done: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> done_q);
    a_r6_interfere_fails: assert property (@(posedge clk) disable iff (rst)
        interfere |=> !ok_q);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  snoop_valid,
    input  logic [ADDR_W-1:0]     snoop_addr,
    input  logic                  irq_taken,
    output logic                  sc_done,
    output logic                  sc_success
);
    op_e   op;
    logic  is_ll, is_sc, is_ls;
    resv_t resv;

    always_comb begin
        op    = op_e'(req_op);
        is_ll = req_valid && (op == OP_LL);
        is_sc = req_valid && (op == OP_SC);
        is_ls = req_valid && (op == OP_LOAD || op == OP_STORE);
    end

    // probe 0: SC address vs reservation
    // probe 1: snoop vs reservation
    // probe 2: snoop vs the line a concurrent LL is about to reserve
    logic  probe_en   [N_PROBES];
    tag_t  probe_ref  [N_PROBES];
    addr_t probe_addr [N_PROBES];
    logic  probe_hit  [N_PROBES];

    always_comb begin
        probe_en[0]   = resv.valid;
        probe_ref[0]  = resv.tag;
        probe_addr[0] = req_addr;
        probe_en[1]   = resv.valid && snoop_valid;
        probe_ref[1]  = resv.tag;
        probe_addr[1] = snoop_addr;
        probe_en[2]   = snoop_valid;
        probe_ref[2]  = line_of(req_addr);
        probe_addr[2] = snoop_addr;
    end

    for (genvar p = 0; p < N_PROBES; p++) begin : g_probe
        llsc_line_match u_match (
            .en      (probe_en[p]),
            .ref_tag (probe_ref[p]),
            .addr    (probe_addr[p]),
            .hit     (probe_hit[p])
        );
    end

    logic sc_line_hit, snoop_hit, ll_blocked, set_en, kill, interfere;

    always_comb begin
        sc_line_hit = probe_hit[0];
        snoop_hit   = probe_hit[1];
        ll_blocked  = irq_taken || probe_hit[2];
        set_en      = is_ll && !ll_blocked;
        kill        = irq_taken || snoop_hit || is_ls || is_sc || is_ll;
        interfere   = irq_taken || snoop_hit;
    end

    llsc_resv_reg u_resv (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_en),
        .set_tag (line_of(req_addr)),
        .kill    (kill),
        .resv    (resv)
    );

    llsc_sc_eval u_eval (
        .clk       (clk),
        .rst       (rst),
        .sc_req    (is_sc),
        .line_hit  (sc_line_hit),
        .interfere (interfere),
        .done      (sc_done),
        .ok        (sc_success)
    );

    a_r2_done_follows_sc: assert property (@(posedge clk) disable iff (rst)
        is_sc |=> sc_done);
    a_r5_own_access_cancels: assert property (@(posedge clk) disable iff (rst)
        is_ls |=> !resv.valid);
    a_r7_sc_clears: assert property (@(posedge clk) disable iff (rst)
        is_sc |=> !resv.valid);
    a_r9_no_resv_fails: assert property (@(posedge clk) disable iff (rst)
        (is_sc && !resv.valid) |=> !sc_success);
    a_r4_snoop_cancels: assert property (@(posedge clk) disable iff (rst)
        (snoop_hit && !is_ll) |=> !resv.valid);
    a_r11_blocked_ll: assert property (@(posedge clk) disable iff (rst)
        (is_ll && ll_blocked) |=> !resv.valid);
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [31:0] req_addr;
    logic        snoop_valid;
    logic [31:0] snoop_addr;
    logic        irq_taken;
    logic        sc_done, sc_success;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    localparam logic [2:0] NONE = 3'd0, LD = 3'd1, ST = 3'd2, LL = 3'd3, SC = 3'd4;

    always #4 clk = ~clk;

    llsc_monitor i_llsc_monitor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .irq_taken(irq_taken), .sc_done(sc_done), .sc_success(sc_success)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle at a negedge; returns at the next negedge.
    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic sv, input logic [31:0] sa, input logic irq);
        req_valid = v; req_op = op; req_addr = a;
        snoop_valid = sv; snoop_addr = sa; irq_taken = irq;
        @(negedge clk);
    endtask

    task automatic req(input logic [2:0] op, input logic [31:0] a);
        step(1'b1, op, a, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, NONE, 32'h0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic sc_check(input string r, input logic [31:0] a, input logic exp);
        req(SC, a);
        chk({r, " sc_done"}, sc_done, 1'b1);
        chk({r, " sc_success"}, sc_success, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        idle();
        chk("R1 sc_done", sc_done, 1'b0);
        chk("R1 sc_success", sc_success, 1'b0);
        sc_check("R9", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_basic();
        req(LL, 32'h0000_1000);
        idle();
        sc_check("R2", 32'h0000_103C, 1'b1);
        idle();
        chk("R2 pulse ends", sc_done, 1'b0);
        chk("R2 success ends", sc_success, 1'b0);
    endtask

    task automatic t_mismatch();
        req(LL, 32'h0000_1000);
        sc_check("R3", 32'h0000_1040, 1'b0);
    endtask

    task automatic t_snoop();
        req(LL, 32'h0000_2000);
        step(1'b0, NONE, 32'h0, 1'b1, 32'h0000_2010, 1'b0);
        sc_check("R4 between", 32'h0000_2000, 1'b0);
        req(LL, 32'h0000_2000);
        step(1'b0, NONE, 32'h0, 1'b1, 32'h0000_3000, 1'b0);
        sc_check("R4 other line", 32'h0000_2000, 1'b1);
        req(LL, 32'h0000_2000);
        step(1'b1, SC, 32'h0000_2008, 1'b1, 32'h0000_203F, 1'b0);
        chk("R4 same cycle", sc_success, 1'b0);
    endtask

    task automatic t_own();
        req(LL, 32'h0000_4000);
        req(LD, 32'h0009_0000);
        sc_check("R5 load", 32'h0000_4000, 1'b0);
        req(LL, 32'h0000_4000);
        req(ST, 32'h0000_4000);
        sc_check("R5 store", 32'h0000_4000, 1'b0);
    endtask

    task automatic t_irq();
        req(LL, 32'h0000_5000);
        step(1'b0, NONE, 32'h0, 1'b0, 32'h0, 1'b1);
        sc_check("R6 between", 32'h0000_5000, 1'b0);
        req(LL, 32'h0000_5000);
        step(1'b1, SC, 32'h0000_5000, 1'b0, 32'h0, 1'b1);
        chk("R6 same cycle", sc_success, 1'b0);
    endtask

    task automatic t_clear();
        req(LL, 32'h0000_6000);
        sc_check("R7 first", 32'h0000_6000, 1'b1);
        sc_check("R7 second", 32'h0000_6000, 1'b0);
    endtask

    task automatic t_replace();
        req(LL, 32'h0000_7000);
        req(LL, 32'h0000_8000);
        sc_check("R8 old line", 32'h0000_7000, 1'b0);
        req(LL, 32'h0000_7000);
        req(LL, 32'h0000_8000);
        sc_check("R8 new line", 32'h0000_8004, 1'b1);
    endtask

    task automatic t_idle();
        req(LL, 32'h0000_9000);
        for (int i = 0; i < 6; i++) step(1'b0, (i % 2 == 0) ? LD : SC, 32'h0000_9000, 1'b0, 32'h0, 1'b0);
        req(NONE, 32'h0000_9000);
        chk("R10 no stray result", sc_done, 1'b0);
        sc_check("R10", 32'h0000_9000, 1'b1);
    endtask

    task automatic t_ll_same_cycle();
        step(1'b1, LL, 32'h0000_A000, 1'b1, 32'h0000_A020, 1'b0);
        sc_check("R11 snoop own line", 32'h0000_A000, 1'b0);
        step(1'b1, LL, 32'h0000_A000, 1'b1, 32'h0000_B000, 1'b0);
        sc_check("R11 snoop other line", 32'h0000_A000, 1'b1);
        step(1'b1, LL, 32'h0000_A000, 1'b0, 32'h0, 1'b1);
        sc_check("R11 irq", 32'h0000_A000, 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_op = NONE; req_addr = 0;
        snoop_valid = 0; snoop_addr = 0; irq_taken = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_snoop();
        t_own();
        t_irq();
        t_clear();
        t_replace();
        t_idle();
        t_ll_same_cycle();
        idle();
        summary();
    end
endmodule